// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns addresses issued by PCI bus masters for DMA into system physical addresses. Software programs four windows through a 64-bit register port. Each window has a base, a size mask and a translated base, and a shared control word sets options for all of them. An incoming 32-bit address is compared against the windows in a fixed order. The first window that hits supplies the result. That result is either a direct offset into the translated base, or a page-table lookup. For the lookup, the block computes an entry address, fetches a 64-bit entry through a memory request port, checks the entry's valid bit, and builds the physical page address from it.

Addresses wider than 32 bits go down one of two paths, and each path is enabled by its own bit:
- A flat window, enabled by a control bit, passes the low 35 address bits straight through.
- A page-table window, enabled on the last window, serves the upper dual-address range.

One translation runs at a time. The request, response and memory ports all use valid/ready handshakes. A request is taken only while the block is idle. A response stays valid, with its hit flag and address held, until the consumer raises ready. A memory request stays valid, with its address held, until memory raises ready. The memory response has no ready: the memory side returns exactly one beat per accepted request.

Top module: `dma_xlate`

## Requirements
- R1: After reset, the block shows `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0. Every register reads 0, except the last window's base, which reads 0x2.
- R2: Register offsets are as follows, with register data at bits [63:0]:
  - window bases at 0x000+0x40·i, kept bits [31:20] plus bit 1 (page-table mode) and bit 0 (enable);
  - the last base (0x0C0) instead keeps bits [31:20], bit 40 (dual-address enable) and bit 0, and always reads bit 1 as 1;
  - masks at 0x100+0x40·i, kept bits [31:20];
  - translated bases at 0x200+0x40·i, kept bits [34:10];
  - control at 0x300, where only the bits set in 0x00001CFF0FC7FF change.
  Any other offset reads 0.
- R3: For a 32-bit address, an enabled window hits when (addr & ~(mask|0xFFFFF)) equals base[31:20]<<20. In direct mode it returns hit=1 and paddr = (tba & ~ext) | (addr & ext), with ext = mask|0xFFFFF. An address that no window hits returns hit=0 and paddr=0.
- R4: When several windows hit, the lowest-numbered window wins.
- R5: The last window takes part in 32-bit lookup only while its bit 40 is clear. When that bit is set and a 32-bit address falls in the window, the result is a miss and no memory request is made.
- R6: With control bit 5 set, every 32-bit address from 0x80000 to 0xFFFFF inclusive misses, whatever the windows hold.
- R7: In page-table mode the block issues one memory read at entry address (tba & ~(mask>>10)) | ((addr & (mask|0xFE000)) >> 10). An entry with bit 0 clear gives a miss. Otherwise paddr = (entry & 0x3FFFFE)<<12 | addr[12:0].
- R8: With control bit 6 set, an address in [0x100_0000_0000, 0x200_0000_0000) hits with paddr = addr & 0x7_FFFF_FFFF. With bit 6 clear, such an address misses.
- R9: An address in [0x800_0000_0000, 0xFFF_FFFF_FFFF], with both bit 40 and bit 0 of the last base set, fetches the entry at (tba3 & 0x7FFC00000) | ((addr & 0xFFFFE000) >> 10). That entry is then used as in R7.
- R10: Back-pressure rules:
  - `req_ready` is low from acceptance until the response handshake completes;
  - `rsp_valid`, `rsp_hit` and `rsp_paddr` hold while `rsp_ready` is low;
  - `mem_req_valid` and `mem_req_addr` hold while `mem_req_ready` is low.
- R11: A memory response with `mem_rsp_err`=1 gives a miss, even if the returned entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register byte offset |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data for `csr_addr` |
| req_valid | input | 1 | DMA address valid |
| req_ready | output | 1 | Translator idle, request accepted |
| req_addr | input | 64 | PCI DMA address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_hit | output | 1 | 1 = translated, 0 = miss |
| rsp_paddr | output | 35 | Physical address (0 on miss) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 35 | Entry address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry word |
| mem_rsp_err | input | 1 | Memory read failed |

## Verification
The in-RTL properties assume three things about the block's inputs:
- software changes registers only while no translation is in flight;
- memory returns exactly one response beat for each accepted read, and never before the read was accepted;
- `mem_rsp_err` is meaningful only together with `mem_rsp_valid`.

The directed bench keeps to these rules. It performs every register write between transactions. Its memory model answers a read only after holding `mem_req_ready` low for one cycle and then accepting the read, and it drives the error flag only in the beat it returns. It also stalls `rsp_ready` for a cycle on every response, so the hold rules are exercised on each transaction.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;
  typedef enum logic [1:0] {LK_MISS, LK_DIRECT, LK_FETCH} lk_kind_e;

  typedef struct packed {
    logic [63:0] base;
    logic [63:0] mask;
    logic [63:0] tba;
  } win_regs_t;

  localparam logic [63:0] BASE_KEEP = 64'h0000_0000_FFF0_0003;
  localparam logic [63:0] MASK_KEEP = 64'h0000_0000_FFF0_0000;
  localparam logic [63:0] TBA_KEEP  = 64'h0000_0007_FFFF_FC00;
  localparam logic [63:0] CTL_KEEP  = 64'h0000_1CFF_0FC7_FF;
endpackage

// File: rtl/dma_xlate_csr.sv
module dma_xlate_csr
  import dma_xlate_pkg::*;
#(
  parameter int NWIN    = 4,
  parameter int CSR_AW  = 12,
  parameter int DAC_BIT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  output win_regs_t         win [NWIN],
  output logic [63:0]       ctl
);
  localparam int IDX_W = CSR_AW - 6;
  localparam int LAST  = NWIN - 1;
  localparam logic [63:0] LAST_KEEP = 64'hFFF0_0001 | (64'd1 << DAC_BIT);

  logic [IDX_W-1:0] slot;
  logic             aligned;

  assign slot    = csr_addr[CSR_AW-1:6];
  assign aligned = (csr_addr[5:0] == 6'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) win[i] <= '0;
      win[LAST].base <= 64'h2;
      ctl <= '0;
    end else if (csr_we && aligned) begin
      for (int i = 0; i < NWIN; i++) begin
        if (slot == IDX_W'(i))
          win[i].base <= (i == LAST) ? ((csr_wdata & LAST_KEEP) | 64'h2)
                                     : (csr_wdata & BASE_KEEP);
        if (slot == IDX_W'(NWIN + i))
          win[i].mask <= csr_wdata & MASK_KEEP;
        if (slot == IDX_W'(2*NWIN + i))
          win[i].tba <= csr_wdata & TBA_KEEP;
      end
      if (slot == IDX_W'(3*NWIN))
        ctl <= (ctl & ~CTL_KEEP) | (csr_wdata & CTL_KEEP);
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (aligned) begin
      for (int i = 0; i < NWIN; i++) begin
        if (slot == IDX_W'(i))          csr_rdata = win[i].base;
        if (slot == IDX_W'(NWIN + i))   csr_rdata = win[i].mask;
        if (slot == IDX_W'(2*NWIN + i)) csr_rdata = win[i].tba;
      end
      if (slot == IDX_W'(3*NWIN)) csr_rdata = ctl;
    end
  end

  a_r2_last_sg_forced: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && aligned && slot == IDX_W'(LAST) |=> win[LAST].base[1]);
endmodule

// File: rtl/dma_xlate_lookup.sv
module dma_xlate_lookup
  import dma_xlate_pkg::*;
#(
  parameter int NWIN    = 4,
  parameter int PA_W    = 35,
  parameter int DAC_BIT = 40
) (
  input  logic [63:0]     addr,
  input  win_regs_t       win [NWIN],
  input  logic [63:0]     ctl,
  output lk_kind_e        kind,
  output logic [PA_W-1:0] xaddr
);
  localparam int LAST = NWIN - 1;

  logic [NWIN-1:0] w_hit;
  logic [NWIN-1:0] w_sg;
  logic [63:0]     w_res [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [63:0] ext;
    assign ext      = {32'h0, win[g].mask[31:0] | 32'h000F_FFFF};
    assign w_hit[g] = win[g].base[0] &&
                      ((addr & ~ext) == {32'h0, win[g].base[31:20], 20'h0});
    assign w_sg[g]  = win[g].base[1];
    assign w_res[g] = w_sg[g]
      ? ((win[g].tba & ~(win[g].mask >> 10)) | ((addr & (win[g].mask | 64'hF_E000)) >> 10))
      : ((win[g].tba & ~ext) | (addr & ext));
  end

  logic        sac, hole, dac_en;
  logic [63:0] r;

  always_comb begin
    sac    = (addr[63:32] == 32'h0);
    hole   = ctl[5] && (addr[31:0] >= 32'h0008_0000) && (addr[31:0] <= 32'h000F_FFFF);
    dac_en = win[LAST].base[DAC_BIT];
    kind   = LK_MISS;
    r      = '0;
    if (sac) begin
      if (!hole) begin
        for (int i = LAST; i >= 0; i--) begin
          if (w_hit[i] && !(i == LAST && dac_en)) begin
            kind = w_sg[i] ? LK_FETCH : LK_DIRECT;
            r    = w_res[i];
          end
        end
      end
    end else if (addr[63:40] == 24'h1 && ctl[6]) begin
      kind = LK_DIRECT;
      r    = addr & 64'h7_FFFF_FFFF;
    end else if (addr[63:44] == 20'h0 && addr[43] && dac_en && win[LAST].base[0]) begin
      kind = LK_FETCH;
      r    = (win[LAST].tba & 64'h7_FFC0_0000) | ((addr & 64'hFFFF_E000) >> 10);
    end
    xaddr = r[PA_W-1:0];
  end
endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dma_xlate_pkg::*;
#(
  parameter int NWIN    = 4,
  parameter int CSR_AW  = 12,
  parameter int PA_W    = 35,
  parameter int DAC_BIT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_RESP} state_e;

  win_regs_t       win [NWIN];
  logic [63:0]     ctl;
  lk_kind_e        lk_kind;
  logic [PA_W-1:0] lk_addr;
  state_e          state;
  logic [12:0]     offs_q;

  dma_xlate_csr #(.NWIN(NWIN), .CSR_AW(CSR_AW), .DAC_BIT(DAC_BIT)) u_csr (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata, .win, .ctl
  );

  dma_xlate_lookup #(.NWIN(NWIN), .PA_W(PA_W), .DAC_BIT(DAC_BIT)) u_lookup (
    .addr(req_addr), .win, .ctl, .kind(lk_kind), .xaddr(lk_addr)
  );

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_RESP);
  assign mem_req_valid = (state == ST_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      offs_q       <= '0;
      rsp_hit      <= 1'b0;
      rsp_paddr    <= '0;
      mem_req_addr <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          offs_q <= req_addr[12:0];
          case (lk_kind)
            LK_FETCH: begin
              mem_req_addr <= lk_addr;
              state        <= ST_FETCH;
            end
            LK_DIRECT: begin
              rsp_hit   <= 1'b1;
              rsp_paddr <= lk_addr;
              state     <= ST_RESP;
            end
            default: begin
              rsp_hit   <= 1'b0;
              rsp_paddr <= '0;
              state     <= ST_RESP;
            end
          endcase
        end
        ST_FETCH: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          rsp_hit   <= !mem_rsp_err && mem_rsp_data[0];
          rsp_paddr <= (!mem_rsp_err && mem_rsp_data[0])
                       ? PA_W'({mem_rsp_data[21:1], offs_q}) : '0;
          state     <= ST_RESP;
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_paddr));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  a_r6_hole_miss: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ctl[5] && req_addr >= 64'h8_0000 && req_addr <= 64'hF_FFFF
    |=> rsp_valid && !rsp_hit);

  a_r11_err_miss: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_err |=> !rsp_hit);
endmodule

// File: tb/test_dma_xlate.sv
module test_dma_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 35;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            csr_we = 0;
  logic [11:0]     csr_addr = '0;
  logic [63:0]     csr_wdata = '0;
  logic [63:0]     csr_rdata;
  logic            req_valid = 0;
  logic            req_ready;
  logic [63:0]     req_addr = '0;
  logic            rsp_valid;
  logic            rsp_ready = 0;
  logic            rsp_hit;
  logic [PA_W-1:0] rsp_paddr;
  logic            mem_req_valid;
  logic            mem_req_ready = 0;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid = 0;
  logic [63:0]     mem_rsp_data = '0;
  logic            mem_rsp_err = 0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xlate i_dma_xlate (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .req_valid, .req_ready, .req_addr, .rsp_valid, .rsp_ready, .rsp_hit, .rsp_paddr,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data, .mem_rsp_err
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic csr_rd_chk(input string rq, input logic [11:0] a, input logic [63:0] exp);
    @(negedge clk); csr_addr = a; #1;
    chk(csr_rdata == exp, rq, csr_rdata, exp);
  endtask

  // One transaction; memory model stalls mem_req_ready and rsp_ready one cycle each.
  task automatic xlate(input string rq, input logic [63:0] a, input bit fetch,
                       input logic [63:0] exp_pte, input logic [63:0] entry, input bit err,
                       input bit exp_hit, input logic [63:0] exp_pa);
    @(negedge clk); req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0;
    chk(!req_ready, {rq, " R10 busy after accept"}, 64'(req_ready), 64'd0);
    if (fetch) begin
      chk(mem_req_valid && 64'(mem_req_addr) == exp_pte, {rq, " entry address"}, 64'(mem_req_addr), exp_pte);
      @(negedge clk);
      chk(mem_req_valid && 64'(mem_req_addr) == exp_pte, {rq, " R10 mem request held"}, 64'(mem_req_addr), exp_pte);
      mem_req_ready = 1;
      @(negedge clk); mem_req_ready = 0;
      mem_rsp_valid = 1; mem_rsp_data = entry; mem_rsp_err = err;
      @(negedge clk); mem_rsp_valid = 0; mem_rsp_err = 0;
    end else begin
      chk(!mem_req_valid, {rq, " no entry fetch"}, 64'(mem_req_valid), 64'd0);
    end
    chk(rsp_valid, {rq, " response valid"}, 64'(rsp_valid), 64'd1);
    @(negedge clk);
    chk(rsp_valid, {rq, " R10 response held"}, 64'(rsp_valid), 64'd1);
    chk(rsp_hit == exp_hit, {rq, " hit"}, 64'(rsp_hit), 64'(exp_hit));
    chk(64'(rsp_paddr) == (exp_hit ? exp_pa : 64'd0), {rq, " paddr"}, 64'(rsp_paddr), exp_hit ? exp_pa : 64'd0);
    rsp_ready = 1;
    @(negedge clk); rsp_ready = 0;
    chk(!rsp_valid && req_ready, {rq, " R10 back to idle"}, {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  task automatic t_reset;
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 idle outputs",
        {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);
    csr_rd_chk("R1 last base", 12'h0C0, 64'h2);
    csr_rd_chk("R1 base0", 12'h000, 64'h0);
    csr_rd_chk("R1 control", 12'h300, 64'h0);
  endtask

  task automatic t_csr_masks;
    csr_wr(12'h000, '1); csr_rd_chk("R2 base0 keep", 12'h000, 64'hFFF0_0003);
    csr_wr(12'h0C0, '1); csr_rd_chk("R2 last base keep", 12'h0C0, 64'h100_FFF0_0003);
    csr_wr(12'h0C0, '0); csr_rd_chk("R2 last base sg forced", 12'h0C0, 64'h2);
    csr_wr(12'h140, '1); csr_rd_chk("R2 mask keep", 12'h140, 64'hFFF0_0000);
    csr_wr(12'h240, '1); csr_rd_chk("R2 tba keep", 12'h240, 64'h7_FFFF_FC00);
    csr_wr(12'h300, '1); csr_rd_chk("R2 control keep", 12'h300, 64'h0000_1CFF_0FC7_FF);
    csr_rd_chk("R2 unmapped", 12'h340, 64'h0);
    csr_wr(12'h000, '0); csr_wr(12'h140, '0); csr_wr(12'h240, '0); csr_wr(12'h300, '0);
  endtask

  task automatic t_direct;
    csr_wr(12'h000, 64'h4000_0001);
    csr_wr(12'h100, 64'h0030_0000);
    csr_wr(12'h200, 64'h1_8000_0000);
    xlate("R3 direct hit", 64'h4012_3456, 0, 0, 0, 0, 1, 64'h1_8012_3456);
    xlate("R3 above window", 64'h4040_0000, 0, 0, 0, 0, 0, 0);
    xlate("R3 below window", 64'h3FFF_FFFF, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    csr_wr(12'h040, 64'h4010_0001);
    csr_wr(12'h240, 64'h2_0000_0000);
    xlate("R4 window0 wins", 64'h4010_0010, 0, 0, 0, 0, 1, 64'h1_8010_0010);
    csr_wr(12'h000, 64'h4000_0000);
    xlate("R4 window1 alone", 64'h4010_0010, 0, 0, 0, 0, 1, 64'h2_0000_0010);
    csr_wr(12'h040, 64'h0);
  endtask

  task automatic t_sg;
    csr_wr(12'h0C0, 64'h5000_0001);
    csr_wr(12'h2C0, 64'h1000_0000);
    xlate("R7 valid entry", 64'h5000_6123, 1, 64'h1000_0018, 64'h12_3401, 0, 1, 64'h1_2340_0123);
    xlate("R7 invalid entry", 64'h5000_6123, 1, 64'h1000_0018, 64'h12_3400, 0, 0, 0);
    xlate("R11 memory error", 64'h5000_6123, 1, 64'h1000_0018, 64'h12_3401, 1, 0, 0);
  endtask

  task automatic t_dac_exclude;
    csr_wr(12'h0C0, 64'h100_5000_0001);
    xlate("R5 last window excluded", 64'h5000_6123, 0, 0, 0, 0, 0, 0);
    csr_wr(12'h0C0, 64'h0);
  endtask

  task automatic t_hole;
    csr_wr(12'h080, 64'h1);
    csr_wr(12'h280, 64'h3_0000_0000);
    xlate("R6 hole off", 64'h9_0000, 0, 0, 0, 0, 1, 64'h3_0009_0000);
    csr_wr(12'h300, 64'h20);
    xlate("R6 hole low edge", 64'h8_0000, 0, 0, 0, 0, 0, 0);
    xlate("R6 hole high edge", 64'hF_FFFF, 0, 0, 0, 0, 0, 0);
    xlate("R6 below hole", 64'h7_FFFF, 0, 0, 0, 0, 1, 64'h3_0007_FFFF);
    csr_wr(12'h300, 64'h0);
  endtask

  task automatic t_monster;
    xlate("R8 flat disabled", 64'h1AB_CDEF_0123, 0, 0, 0, 0, 0, 0);
    csr_wr(12'h300, 64'h40);
    xlate("R8 flat hit", 64'h1AB_CDEF_0123, 0, 0, 0, 0, 1, 64'h3_CDEF_0123);
    xlate("R8 above flat", 64'h200_0000_0000, 0, 0, 0, 0, 0, 0);
    csr_wr(12'h300, 64'h0);
  endtask

  task automatic t_dac_sg;
    csr_wr(12'h0C0, 64'h100_0000_0001);
    csr_wr(12'h2C0, 64'h4_5600_0000);
    xlate("R9 dual-address fetch", 64'h8AB_1234_5678, 1, 64'h4_5604_8D10, 64'h3F_FFFF, 0, 1, 64'h3_FFFF_F678);
    xlate("R9 below range", 64'h7FF_FFFF_FFFF, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_csr_masks();
    t_direct();
    t_priority();
    t_sg();
    t_dac_exclude();
    t_hole();
    t_monster();
    t_dac_sg();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule